// File: doc/BRIEF.md
# SPI Flash Clock and Chip-Select Timing Generator

This block derives the serial clock and four active-low chip-select lines of a serial flash port from a faster reference clock. A transfer engine requests the start of a frame and later its end. The block then spaces the chip-select and clock edges by four programmable gaps, all counted in reference cycles. It also emits one-cycle strobes that mark the sampling edge and the shifting edge for the selected SPI mode, and it raises an idle flag once nothing is counting.

Configuration comes in as plain inputs: a 4-bit divisor, polarity, phase, a 4-bit select field with a decoder flag, and four 8-bit gap counts. The block takes a copy of these inputs on every cycle it is idle and freezes the copy while a frame or any of its gaps is in progress. Any change made mid-frame therefore waits for the next frame.

Top module: `spi_tgen`

## Requirements
- R1: After reset, csn_o is 4'b1111, sclk_o is 0, idle_o is 1, and sample_o and shift_o are 0.
- R2: While clocking, each sclk_o level lasts (baud_div_i+1) reference cycles, so one clock period is 2*(baud_div_i+1) cycles.
- R3: Whenever csn_o is 4'b1111, sclk_o equals the frozen polarity. In idle it follows cpol_i one cycle later.
- R4: With cs_decode_i low, an active frame drives csn_o low on the single bit indexed by cs_sel_i[1:0]: index 0 gives 1110, 1 gives 1101, 2 gives 1011 and 3 gives 0111.
- R5: With cs_decode_i high, an active frame drives csn_o with cs_sel_i unchanged.
- R6: The first sclk_o transition appears dly_lead_i+baud_div_i+2 cycles after csn_o goes active.
- R7: A frame end takes effect at the first half-period boundary at which sclk_o rests. When the request arrives before the last transition, csn_o rises baud_div_i+dly_trail_i+2 cycles after that transition. A frame that ends before its first edge makes no transition.
- R8: After csn_o rises, idle_o stays low for dly_desel_i+1 cycles. A start request during that time is dropped.
- R9: If a frame's select pattern differs from the previous frame's, csn_o stays inactive for dly_switch_i+1 extra cycles, so it goes active dly_switch_i+2 cycles after the start request. Otherwise it goes active one cycle after the request.
- R10: idle_o is high only while no frame or gap is in progress, and csn_o is 4'b1111 then. A start request is taken only while enable_i is high.
- R11: sample_o and shift_o pulse in the cycle in which sclk_o shows a new level, and never together. With cpha_i=0, sample_o marks the leading (rest-to-active) transition and shift_o the trailing one. With cpha_i=1 the two are swapped.
- R12: Changes to any configuration input after the start request do not affect that frame's gaps, divisor, select pattern, polarity or phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new frames to start |
| frame_start_i | input | 1 | Start request, sampled while idle |
| frame_end_i | input | 1 | End request, sampled during lead gap or clocking |
| baud_div_i | input | 4 | Half-period length minus one |
| cpol_i | input | 1 | Clock rest level |
| cpha_i | input | 1 | Clock phase |
| cs_sel_i | input | 4 | Device index or pre-decoded select value |
| cs_decode_i | input | 1 | 1: pass cs_sel_i through unchanged |
| dly_lead_i | input | 8 | Select-active to clocking gap |
| dly_trail_i | input | 8 | End of clocking to select release gap |
| dly_desel_i | input | 8 | Minimum select-inactive time after a frame |
| dly_switch_i | input | 8 | Extra inactive gap when the device changes |
| sclk_o | output | 1 | Serial clock |
| csn_o | output | 4 | Chip selects, active low |
| sample_o | output | 1 | Sampling-edge strobe |
| shift_o | output | 1 | Shifting-edge strobe |
| idle_o | output | 1 | No frame or gap in progress |

## Verification
The assertions hold on every cycle for these properties: the rest level whenever the selects are inactive, inactive selects while idle, one-hot selects in raw mode, strobes tied to real clock transitions, the frozen configuration copy, and clocking entered only from the lead gap. Gap lengths, the divisor period, the device-switch gap, dropped starts and the effect of mid-frame configuration changes depend on counts and on frame history. Only the bench's scenarios show these, by comparing every cycle against its behavioural model and by timing events between frames.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_CLOCK,
    ST_HOLD,
    ST_DESEL
  } tgen_state_e;
endpackage

// File: rtl/tgen_shadow.sv
module tgen_shadow #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [DIV_W-1:0] baud_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [CS_W-1:0]  sel_i,
  input  logic             decode_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  input  logic [DLY_W-1:0] desel_i,
  input  logic [DLY_W-1:0] switch_i,
  output logic [DIV_W-1:0] baud_o,
  output logic             cpol_o,
  output logic             cpha_o,
  output logic             decode_o,
  output logic [DLY_W-1:0] lead_o,
  output logic [DLY_W-1:0] trail_o,
  output logic [DLY_W-1:0] desel_o,
  output logic [CS_W-1:0]  pat_live_o,
  output logic [CS_W-1:0]  pat_sh_o
);
  localparam int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1;

  logic [CS_W-1:0] sel_q;
  logic [CS_W-1:0] oh_live, oh_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_o   <= '0;
      cpol_o   <= 1'b0;
      cpha_o   <= 1'b0;
      sel_q    <= '0;
      decode_o <= 1'b0;
      lead_o   <= '0;
      trail_o  <= '0;
      desel_o  <= '0;
    end else if (cap_i) begin
      baud_o   <= baud_i;
      cpol_o   <= cpol_i;
      cpha_o   <= cpha_i;
      sel_q    <= sel_i;
      decode_o <= decode_i;
      lead_o   <= lead_i;
      trail_o  <= trail_i;
      desel_o  <= desel_i;
    end
  end

  // active-low one-hot decode of the device index
  for (genvar i = 0; i < CS_W; i++) begin : g_oh
    assign oh_live[i] = (sel_i[IDX_W-1:0] != IDX_W'(i));
    assign oh_sh[i]   = (sel_q[IDX_W-1:0] != IDX_W'(i));
  end

  assign pat_live_o = decode_i ? sel_i : oh_live;
  assign pat_sh_o   = decode_o ? sel_q : oh_sh;

  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable({baud_o, cpol_o, cpha_o, sel_q, decode_o, lead_o, trail_o, desel_o}));
endmodule

// File: rtl/tgen_clkdiv.sv
module tgen_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             end_pend_i,
  input  logic             cpol_live_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] baud_i,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             halt_o
);
  logic [DIV_W-1:0] hcnt_q;
  logic             half_tick;
  logic             lead_edge;

  assign half_tick = run_i && (hcnt_q == baud_i);
  assign halt_o    = half_tick && end_pend_i && (sclk_o == cpol_i);
  assign lead_edge = (sclk_o == cpol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q   <= '0;
      sclk_o   <= 1'b0;
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
    end else begin
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
      if (load_i) sclk_o <= cpol_live_i;
      if (!run_i) begin
        hcnt_q <= '0;
      end else if (half_tick) begin
        hcnt_q <= '0;
        if (!halt_o) begin
          sclk_o   <= ~sclk_o;
          sample_o <= lead_edge ^ cpha_i;
          shift_o  <= ~(lead_edge ^ cpha_i);
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  // R11
  pulse_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || shift_o) |-> (sclk_o != $past(sclk_o)));
  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, shift_o}));
endmodule

// File: rtl/tgen_seq.sv
module tgen_seq
  import spi_tgen_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             halt_i,
  input  logic [CS_W-1:0]  pat_live_i,
  input  logic [CS_W-1:0]  pat_sh_i,
  input  logic [DLY_W-1:0] lead_live_i,
  input  logic [DLY_W-1:0] switch_live_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] trail_i,
  input  logic [DLY_W-1:0] desel_i,
  output tgen_state_e      state_o,
  output logic             cs_on_o,
  output logic             run_o,
  output logic             end_pend_o
);
  tgen_state_e      state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [CS_W-1:0]  last_q;
  logic             have_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      last_q     <= '1;
      have_q     <= 1'b0;
      end_pend_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          end_pend_o <= 1'b0;
          if (enable_i && start_i) begin
            if (have_q && (pat_live_i != last_q)) begin
              state_q <= ST_GAP;
              cnt_q   <= switch_live_i;
            end else begin
              state_q <= ST_SETUP;
              cnt_q   <= lead_live_i;
            end
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            state_q <= ST_SETUP;
            cnt_q   <= lead_i;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_SETUP: begin
          if (end_i) end_pend_o <= 1'b1;
          if (cnt_zero) state_q <= ST_CLOCK;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_CLOCK: begin
          if (halt_i) begin
            state_q    <= ST_HOLD;
            cnt_q      <= trail_i;
            end_pend_o <= 1'b0;
          end else if (end_i) end_pend_o <= 1'b1;
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            state_q <= ST_DESEL;
            cnt_q   <= desel_i;
            last_q  <= pat_sh_i;
            have_q  <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_DESEL: begin
          if (cnt_zero) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cs_on_o = (state_q == ST_SETUP) || (state_q == ST_CLOCK) || (state_q == ST_HOLD);
  assign run_o   = (state_q == ST_CLOCK);

  // R6
  seq_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLOCK && $past(state_q) != ST_CLOCK) |-> ($past(state_q) == ST_SETUP));
endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
  import spi_tgen_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [CS_W-1:0]  cs_sel_i,
  input  logic             cs_decode_i,
  input  logic [DLY_W-1:0] dly_lead_i,
  input  logic [DLY_W-1:0] dly_trail_i,
  input  logic [DLY_W-1:0] dly_desel_i,
  input  logic [DLY_W-1:0] dly_switch_i,
  output logic             sclk_o,
  output logic [CS_W-1:0]  csn_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             idle_o
);
  tgen_state_e      state;
  logic             cs_on, run, end_pend, halt;
  logic [DIV_W-1:0] sh_baud;
  logic             sh_cpol, sh_cpha, sh_decode;
  logic [DLY_W-1:0] sh_lead, sh_trail, sh_desel;
  logic [CS_W-1:0]  pat_live, pat_sh;

  assign idle_o = (state == ST_IDLE);

  tgen_shadow #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) u_shadow (
    .clk_i, .rst_ni,
    .cap_i      (idle_o),
    .baud_i     (baud_div_i),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .sel_i      (cs_sel_i),
    .decode_i   (cs_decode_i),
    .lead_i     (dly_lead_i),
    .trail_i    (dly_trail_i),
    .desel_i    (dly_desel_i),
    .switch_i   (dly_switch_i),
    .baud_o     (sh_baud),
    .cpol_o     (sh_cpol),
    .cpha_o     (sh_cpha),
    .decode_o   (sh_decode),
    .lead_o     (sh_lead),
    .trail_o    (sh_trail),
    .desel_o    (sh_desel),
    .pat_live_o (pat_live),
    .pat_sh_o   (pat_sh)
  );

  tgen_seq #(.DLY_W(DLY_W), .CS_W(CS_W)) u_seq (
    .clk_i, .rst_ni,
    .enable_i      (enable_i),
    .start_i       (frame_start_i),
    .end_i         (frame_end_i),
    .halt_i        (halt),
    .pat_live_i    (pat_live),
    .pat_sh_i      (pat_sh),
    .lead_live_i   (dly_lead_i),
    .switch_live_i (dly_switch_i),
    .lead_i        (sh_lead),
    .trail_i       (sh_trail),
    .desel_i       (sh_desel),
    .state_o       (state),
    .cs_on_o       (cs_on),
    .run_o         (run),
    .end_pend_o    (end_pend)
  );

  tgen_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i       (run),
    .load_i      (idle_o),
    .end_pend_i  (end_pend),
    .cpol_live_i (cpol_i),
    .cpol_i      (sh_cpol),
    .cpha_i      (sh_cpha),
    .baud_i      (sh_baud),
    .sclk_o      (sclk_o),
    .sample_o    (sample_o),
    .shift_o     (shift_o),
    .halt_o      (halt)
  );

  assign csn_o = cs_on ? pat_sh : '1;

  // R3
  rest_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_o == '1) |-> (sclk_o == sh_cpol));
  // R10
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (csn_o == '1));
  // R4
  raw_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sh_decode && csn_o != '1) |-> ($countones(~csn_o) == 1));
endmodule

// File: tb/spi_tgen_test.sv
`timescale 1ns/1ps
module spi_tgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic [3:0] baud = 4'd1, sel = 4'd0;
  logic cpol = 1'b0, cpha = 1'b0, decode = 1'b0;
  logic [7:0] d_lead = 8'd2, d_trail = 8'd1, d_desel = 8'd3, d_switch = 8'd4;
  logic sclk, sample, shift, idle;
  logic [3:0] csn;

  int checks = 0, errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_tgen uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .frame_start_i(frame_start), .frame_end_i(frame_end),
    .baud_div_i(baud), .cpol_i(cpol), .cpha_i(cpha),
    .cs_sel_i(sel), .cs_decode_i(decode),
    .dly_lead_i(d_lead), .dly_trail_i(d_trail),
    .dly_desel_i(d_desel), .dly_switch_i(d_switch),
    .sclk_o(sclk), .csn_o(csn), .sample_o(sample), .shift_o(shift), .idle_o(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] f_pat(input logic [3:0] s, input logic d);
    return d ? s : (4'hF & ~(4'h1 << s[1:0]));
  endfunction

  // behavioural reference: phase 0 idle,1 switch gap,2 lead,3 clocking,4 trail,5 deselect
  int m_ph, m_cnt, m_h, c_b, c_s, c_t, c_d;
  logic m_sclk, m_endp, m_samp, m_shift, m_have, c_cpol, c_cpha;
  logic [3:0] m_last, c_pat;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_h = 0; m_sclk = 0; m_endp = 0; m_samp = 0; m_shift = 0;
      m_have = 0; m_last = 4'hF; c_pat = 4'hF; c_cpol = 0; c_cpha = 0;
      c_b = 0; c_s = 0; c_t = 0; c_d = 0;
    end else begin
      m_samp = 0; m_shift = 0;
      case (m_ph)
        0: begin
          m_sclk = cpol; c_cpol = cpol; c_cpha = cpha; c_b = baud;
          c_s = d_lead; c_t = d_trail; c_d = d_desel; c_pat = f_pat(sel, decode);
          m_endp = 0;
          if (enable && frame_start) begin
            if (m_have && c_pat != m_last) begin m_ph = 1; m_cnt = d_switch; end
            else begin m_ph = 2; m_cnt = d_lead; end
          end
        end
        1: if (m_cnt == 0) begin m_ph = 2; m_cnt = c_s; end else m_cnt--;
        2: begin
          if (frame_end) m_endp = 1;
          if (m_cnt == 0) begin m_ph = 3; m_h = 0; end else m_cnt--;
        end
        3: begin
          if (m_h == c_b) begin
            m_h = 0;
            if (m_endp && m_sclk == c_cpol) begin
              m_ph = 4; m_cnt = c_t; m_endp = 0;
            end else begin
              m_samp  = (m_sclk == c_cpol) ^ c_cpha;
              m_shift = !m_samp;
              m_sclk  = !m_sclk;
              if (frame_end) m_endp = 1;
            end
          end else begin
            m_h++;
            if (frame_end) m_endp = 1;
          end
        end
        4: if (m_cnt == 0) begin m_ph = 5; m_cnt = c_d; m_last = c_pat; m_have = 1; end
           else m_cnt--;
        default: if (m_cnt == 0) m_ph = 0; else m_cnt--;
      endcase
    end
  end

  // event monitor and per-cycle comparison
  logic [3:0] prev_csn = 4'hF, fall_val = 4'hF;
  logic prev_sclk = 1'b0, prev_idle = 1'b1;
  int t_fall, t_first, t_last, t_rise, t_idle, edges, t_req;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] e_cs;
      string cs_tag;
      e_cs = (m_ph >= 2 && m_ph <= 4) ? c_pat : 4'hF;
      case (m_ph)
        1: cs_tag = "R9";
        2: cs_tag = "R6";
        4: cs_tag = "R7";
        5: cs_tag = "R8";
        default: cs_tag = c_pat == f_pat(4'd0, 1'b0) || !decode ? "R4" : "R5";
      endcase
      chk(csn == e_cs, cs_tag, csn, e_cs);
      chk(sclk == m_sclk, (m_ph == 3) ? "R2" : "R3", sclk, m_sclk);
      chk(idle == (m_ph == 0), "R10", idle, m_ph == 0);
      chk({sample, shift} == {m_samp, m_shift}, "R11", {sample, shift}, {m_samp, m_shift});
      if (prev_csn == 4'hF && csn != 4'hF) begin t_fall = cyc; fall_val = csn; edges = 0; end
      if (csn != 4'hF && sclk != prev_sclk) begin
        if (edges == 0) t_first = cyc;
        t_last = cyc;
        edges++;
      end
      if (prev_csn != 4'hF && csn == 4'hF) t_rise = cyc;
      if (!prev_idle && idle) t_idle = cyc;
      prev_csn = csn; prev_sclk = sclk; prev_idle = idle;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic kick();
    step(); frame_start = 1'b1; t_req = cyc;
    step(); frame_start = 1'b0;
  endtask

  task automatic finish(input int n);
    while (csn == 4'hF) step();
    while (edges < n) step();
    frame_end = 1'b1;
    step(); frame_end = 1'b0;
    while (!idle) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    chk(csn == 4'hF, "R1", csn, 15);
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(idle == 1'b1, "R1", idle, 1);
    chk({sample, shift} == 2'b00, "R1", {sample, shift}, 0);
    enable = 1'b1;

    // F1: mode 0, device 0, divisor 1
    kick(); finish(4);
    chk(t_fall - t_req == 1, "R9", t_fall - t_req, 1);
    chk(fall_val == 4'b1110, "R4", fall_val, 4'b1110);
    chk(t_first - t_fall == 2 + 1 + 2, "R6", t_first - t_fall, 5);
    chk(t_last - t_first == 3 * 2, "R2", t_last - t_first, 6);
    chk(edges == 4, "R7", edges, 4);
    chk(t_rise - t_last == 1 + 1 + 2, "R7", t_rise - t_last, 4);
    chk(t_idle - t_rise == 3 + 1, "R8", t_idle - t_rise, 4);

    // F2: same device, phase 1
    cpha = 1'b1;
    kick(); finish(2);
    chk(t_fall - t_req == 1, "R9", t_fall - t_req, 1);
    chk(fall_val == 4'b1110, "R4", fall_val, 4'b1110);

    // F3: device 2, polarity 1, divisor 0, zero gaps
    sel = 4'd2; cpol = 1'b1; baud = 4'd0; d_lead = 8'd0; d_trail = 8'd0; d_desel = 8'd0;
    step(); step();
    chk(sclk == 1'b1, "R3", sclk, 1);
    kick(); finish(6);
    chk(t_fall - t_req == 4 + 2, "R9", t_fall - t_req, 6);
    chk(fall_val == 4'b1011, "R4", fall_val, 4'b1011);
    chk(t_first - t_fall == 0 + 0 + 2, "R6", t_first - t_fall, 2);

    // F4: decoded select, configuration disturbed after the request
    decode = 1'b1; sel = 4'b1010; baud = 4'd3; cpol = 1'b0; cpha = 1'b0;
    d_lead = 8'd1; d_trail = 8'd2; d_desel = 8'd2; d_switch = 8'd4;
    step();
    kick();
    baud = 4'd0; d_lead = 8'd7; d_trail = 8'd0; d_switch = 8'd0; sel = 4'd5; cpol = 1'b1;
    finish(2);
    chk(t_fall - t_req == 4 + 2, "R12", t_fall - t_req, 6);
    chk(fall_val == 4'b1010, "R5", fall_val, 4'b1010);
    chk(t_first - t_fall == 1 + 3 + 2, "R12", t_first - t_fall, 6);
    chk(t_rise - t_last == 3 + 2 + 2, "R7", t_rise - t_last, 7);
    chk(t_idle - t_rise == 2 + 1, "R8", t_idle - t_rise, 3);

    // F5: start while disabled is not taken
    enable = 1'b0;
    kick();
    repeat (6) step();
    chk(idle == 1'b1, "R10", idle, 1);
    chk(csn == 4'hF, "R10", csn, 15);
    enable = 1'b1;

    // F6: end before any clock edge, device 3
    decode = 1'b0; sel = 4'd3; baud = 4'd2; cpol = 1'b0;
    d_lead = 8'd1; d_trail = 8'd0; d_desel = 8'd1; d_switch = 8'd1;
    step();
    kick(); finish(0);
    chk(edges == 0, "R7", edges, 0);
    chk(fall_val == 4'b0111, "R4", fall_val, 4'b0111);

    // F7: start during the deselect gap is dropped
    d_desel = 8'd5;
    step();
    kick();
    while (csn == 4'hF) step();
    while (edges < 2) step();
    frame_end = 1'b1; step(); frame_end = 1'b0;
    while (csn != 4'hF) step();
    frame_start = 1'b1; step(); frame_start = 1'b0;
    while (!idle) step();
    repeat (3) step();
    chk(idle == 1'b1, "R8", idle, 1);
    chk(csn == 4'hF, "R8", csn, 15);

    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule